// File: doc/BRIEF.md
# Display Port Lane Mapper

This block is the lane-control stage of a display output port with up to four serial lanes. Each cycle it takes one symbol per lane from the link layer and routes the symbols through a lane-reversal crossbar. It then gates each physical lane with that lane's enable, so a lane that is off carries zeros. The reversal pattern depends on the port's role. An ordinary port swaps its lanes end to end. A primary port that lends two of its lanes to a secondary port swaps only the two lanes it keeps. A secondary port never reverses.

The lane enables follow a lane-count field that holds the number of lanes minus one. When the port is switched on, the lanes turn on one at a time in ascending order. When it is switched off, they turn off in descending order. A programmable delay, counted in symbol clocks, separates the steps, and a delay of zero moves all lanes in one step. A lane count that the port cannot support is clamped to the largest count it can support, and a sticky error flag is set. An idle output shows when no lane is driven.

Top module: `dp_lane_steer`

## Requirements
- R1: On an ordinary port (role code 1 or 3), a lane-count field of 0, 1 or 3 enables 1, 2 or 4 lanes. Lane k is enable bit k, and the enabled lanes always form a contiguous group starting at lane 0.
- R2: The port capability is 2 lanes for the secondary role (code 2), 2 lanes for the primary role (code 0) with split set, and 4 lanes otherwise. A field value of 2, or a count above the capability, enables the capability count.
- R3: cfg_err goes high on the clock edge after any cycle in which cfg_en is high and the field is unsupported (R2). It then stays high until reset.
- R4: With reversal captured on an ordinary port, or on a primary port without split, output lane i carries input lane 3-i.
- R5: With reversal captured on a primary port with split set, output lanes 0 and 1 carry input lanes 1 and 0.
- R6: On a secondary port, output lane i carries input lane i whatever the reversal setting.
- R7: The reversal setting is captured only on a clock edge where cfg_en is low and idle is high. A change of cfg_rev at any other time has no effect on the mapping.
- R8: With delay D>0, when the lane target rises, one more lane turns on at the first clock edge and at every D-th edge after it, in ascending lane order.
- R9: With delay D>0, when the lane target falls, the highest enabled lane turns off at the first clock edge and then one more every D edges, in descending order.
- R10: With delay 0, all lanes reach the target count on the first clock edge.
- R11: idle is high exactly when no lane enable is high. It rises on the edge that removes the last lane and falls on the edge that turns on the first lane. Reset leaves all lanes off, idle high, cfg_err low and the captured reversal cleared.
- R12: An output lane whose enable is low is zero, and this gating is applied after the reversal mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable |
| cfg_rev | input | 1 | Lane-reversal request |
| cfg_lanes | input | 2 | Lane count minus one |
| cfg_dly | input | DLY_W | Stagger delay in symbol clocks |
| cfg_role | input | 2 | 0 primary, 1 or 3 ordinary, 2 secondary |
| cfg_split | input | 1 | Primary port lends two lanes to secondary |
| din | input | 4*SYM_W | Symbols from the link layer, lane i at bits [i*SYM_W +: SYM_W] |
| dout | output | 4*SYM_W | Mapped and gated symbols, same packing |
| lane_en | output | 4 | Per-lane enables |
| idle | output | 1 | No lane is driven |
| cfg_err | output | 1 | Sticky unsupported-count flag |

## Verification
Two kinds of change can land on the same clock edge: an attempt to write the reversal setting, and a change of the lane enables or of the port enable. The bench toggles cfg_rev while the port is enabled, and later while it is disabled and idle. It judges the result by the symbol placement on dout: placement must stay unchanged in the first case and switch in the second. Separate sweeps over delays 1 to 3 compare lane_en and idle, cycle by cycle, with counts computed from the step timing.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ROLE_PRIMARY   = 2'd0,
        ROLE_PLAIN     = 2'd1,
        ROLE_SECONDARY = 2'd2,
        ROLE_PLAIN_ALT = 2'd3
    } role_e;

    typedef struct packed {
        logic [2:0] lanes;
        logic       bad;
    } lane_pick_t;

    function automatic logic [2:0] port_cap(role_e r, logic split);
        if (r == ROLE_SECONDARY)             return 3'd2;
        if (r == ROLE_PRIMARY && split)      return 3'd2;
        return 3'd4;
    endfunction

    function automatic lane_pick_t pick_lanes(logic [1:0] field, logic [2:0] cap);
        lane_pick_t p;
        logic [2:0] want;
        case (field)
            2'd0:    want = 3'd1;
            2'd1:    want = 3'd2;
            2'd3:    want = 3'd4;
            default: want = 3'd0;
        endcase
        if (want == 3'd0 || want > cap) begin
            p.lanes = cap;
            p.bad   = 1'b1;
        end else begin
            p.lanes = want;
            p.bad   = 1'b0;
        end
        return p;
    endfunction

    function automatic logic [1:0] src_lane(logic [1:0] phys, logic rev, role_e r, logic split);
        if (!rev || r == ROLE_SECONDARY) return phys;
        if (r == ROLE_PRIMARY && split)  return (phys < 2'd2) ? (phys ^ 2'd1) : phys;
        return 2'd3 - phys;
    endfunction

    function automatic logic [LANES-1:0] thermo(logic [2:0] n);
        logic [LANES-1:0] t;
        for (int i = 0; i < LANES; i++) t[i] = (3'(i) < n);
        return t;
    endfunction

endpackage

// File: rtl/lane_cfg_decode.sv
module lane_cfg_decode
    import lane_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] field,
    input  role_e      role,
    input  logic       split,
    output logic [2:0] n_lanes,
    output logic       err
);

    lane_pick_t pick;

    always_comb pick = pick_lanes(field, port_cap(role, split));

    assign n_lanes = pick.lanes;

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= err | (en & pick.bad);
    end

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R3
    err_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (en && pick.bad) |=> err);

endmodule

// File: rtl/lane_seq.sv
module lane_seq
    import lane_steer_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       target,
    input  logic [DLY_W-1:0] dly,
    output logic [LANES-1:0] lane_en,
    output logic             idle
);

    logic [2:0]       on_cnt, nxt_cnt;
    logic [DLY_W-1:0] tmr, nxt_tmr;

    always_comb begin
        nxt_cnt = on_cnt;
        nxt_tmr = tmr;
        if (on_cnt == target) begin
            nxt_tmr = '0;
        end else if (dly == '0) begin
            nxt_cnt = target;
            nxt_tmr = '0;
        end else if (tmr == '0) begin
            nxt_cnt = (on_cnt < target) ? on_cnt + 3'd1 : on_cnt - 3'd1;
            nxt_tmr = dly - DLY_W'(1);
        end else begin
            nxt_tmr = tmr - DLY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_cnt <= '0;
            tmr    <= '0;
            idle   <= 1'b1;
        end else begin
            on_cnt <= nxt_cnt;
            tmr    <= nxt_tmr;
            idle   <= (nxt_cnt == 3'd0);
        end
    end

    assign lane_en = thermo(on_cnt);

    // R8
    stagger_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dly) != '0) |-> ($countones(lane_en ^ $past(lane_en)) <= 1));

    // R10
    zero_dly_chk: assert property (@(posedge clk) disable iff (rst)
        (dly == '0) |=> ($countones(lane_en) == int'($past(target))));

endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
    import lane_steer_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic [LANES*SYM_W-1:0] din,
    input  logic [LANES-1:0]       lane_en,
    input  logic                   rev,
    input  role_e                  role,
    input  logic                   split,
    output logic [LANES*SYM_W-1:0] dout
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] PHYS = 2'(i);
        logic [1:0]       src;
        logic [SYM_W-1:0] mapped;

        always_comb begin
            src    = src_lane(PHYS, rev, role, split);
            mapped = din[int'(src)*SYM_W +: SYM_W];
        end

        assign dout[i*SYM_W +: SYM_W] = lane_en[i] ? mapped : '0;
    end

endmodule

// File: rtl/dp_lane_steer.sv
module dp_lane_steer
    import lane_steer_pkg::*;
#(
    parameter int SYM_W = 10,
    parameter int DLY_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_en,
    input  logic                   cfg_rev,
    input  logic [1:0]             cfg_lanes,
    input  logic [DLY_W-1:0]       cfg_dly,
    input  logic [1:0]             cfg_role,
    input  logic                   cfg_split,
    input  logic [LANES*SYM_W-1:0] din,
    output logic [LANES*SYM_W-1:0] dout,
    output logic [LANES-1:0]       lane_en,
    output logic                   idle,
    output logic                   cfg_err
);

    role_e      role;
    logic [2:0] n_lanes;
    logic [2:0] target;
    logic       rev_q;

    assign role   = role_e'(cfg_role);
    assign target = cfg_en ? n_lanes : 3'd0;

    lane_cfg_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_en),
        .field   (cfg_lanes),
        .role    (role),
        .split   (cfg_split),
        .n_lanes (n_lanes),
        .err     (cfg_err)
    );

    lane_seq #(.DLY_W(DLY_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .target  (target),
        .dly     (cfg_dly),
        .lane_en (lane_en),
        .idle    (idle)
    );

    always_ff @(posedge clk) begin
        if (rst)                 rev_q <= 1'b0;
        else if (!cfg_en && idle) rev_q <= cfg_rev;
    end

    lane_xbar #(.SYM_W(SYM_W)) u_xbar (
        .din     (din),
        .lane_en (lane_en),
        .rev     (rev_q),
        .role    (role),
        .split   (cfg_split),
        .dout    (dout)
    );

    // R7
    rev_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en || !idle) |=> $stable(rev_q));

    // R11
    idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (lane_en == '0));

    // R11
    busy_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !idle |-> (lane_en != '0));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        // R12
        gated_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !lane_en[i] |-> (dout[i*SYM_W +: SYM_W] == '0));

        // R6
        sec_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (role == ROLE_SECONDARY && lane_en[i]) |->
                (dout[i*SYM_W +: SYM_W] == din[i*SYM_W +: SYM_W]));
    end

endmodule

// File: tb/tb_dp_lane_steer.sv
module tb_dp_lane_steer;

    localparam int SW = 10;
    localparam int DW = 6;
    localparam int NL = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_en = 1'b0;
    logic            cfg_rev = 1'b0;
    logic [1:0]      cfg_lanes = 2'd3;
    logic [DW-1:0]   cfg_dly = '0;
    logic [1:0]      cfg_role = 2'd1;
    logic            cfg_split = 1'b0;
    logic [NL*SW-1:0] din = '0;
    logic [NL*SW-1:0] dout;
    logic [NL-1:0]   lane_en;
    logic            idle;
    logic            cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dp_lane_steer #(.SYM_W(SW), .DLY_W(DW)) dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_rev(cfg_rev),
        .cfg_lanes(cfg_lanes), .cfg_dly(cfg_dly), .cfg_role(cfg_role),
        .cfg_split(cfg_split), .din(din), .dout(dout), .lane_en(lane_en),
        .idle(idle), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int cap_of(int r, bit s);
        if (r == 2) return 2;
        if (r == 0 && s) return 2;
        return 4;
    endfunction

    function automatic int want_of(int f);
        case (f)
            0: return 1;
            1: return 2;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int src_of(int i, bit rv, int r, bit s);
        if (!rv || r == 2) return i;
        if (r == 0 && s) return (i < 2) ? 1 - i : i;
        return 3 - i;
    endfunction

    function automatic logic [NL-1:0] therm(int n);
        return NL'((1 << n) - 1);
    endfunction

    function automatic logic [NL*SW-1:0] pattern(int p);
        logic [NL*SW-1:0] d;
        for (int i = 0; i < NL; i++) d[i*SW +: SW] = SW'(p * 97 + i * 41 + 5);
        return d;
    endfunction

    function automatic logic [NL*SW-1:0] exp_out(logic [NL*SW-1:0] d, bit rv, int r, bit s, int n);
        logic [NL*SW-1:0] o;
        for (int i = 0; i < NL; i++)
            o[i*SW +: SW] = (i < n) ? d[src_of(i, rv, r, s)*SW +: SW] : '0;
        return o;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        cfg_en = 1'b0;
        repeat (2) tick();
        rst = 1'b0;
        tick();
    endtask

    initial begin
        int exp_err;
        // reset state, R11 and R12
        din = pattern(1);
        repeat (3) tick();
        #1;
        chk(lane_en == '0, "R11", "reset lane_en", 64'(lane_en), 64'd0);
        chk(idle == 1'b1, "R11", "reset idle", 64'(idle), 64'd1);
        chk(cfg_err == 1'b0, "R11", "reset err", 64'(cfg_err), 64'd0);
        chk(dout == '0, "R12", "reset dout", 64'(dout), 64'd0);
        rst = 1'b0;

        // reversal sweep: R4 R5 R6 R12
        for (int r = 0; r < 3; r++) begin
            for (int s = 0; s < 2; s++) begin
                for (int rv = 0; rv < 2; rv++) begin
                    tick();
                    cfg_en = 1'b0; cfg_rev = rv[0]; cfg_role = 2'(r);
                    cfg_split = s[0]; cfg_lanes = 2'd3; cfg_dly = '0;
                    repeat (3) tick();
                    cfg_en = 1'b1;
                    tick();
                    for (int p = 0; p < 3; p++) begin
                        string tag;
                        din = pattern(p + 2 * r + 5 * s);
                        #1;
                        tag = (r == 2) ? "R6" : ((r == 0 && s == 1) ? "R5" : "R4");
                        chk(dout == exp_out(din, rv[0], r, s[0], cap_of(r, s[0])), tag,
                            "mapped dout", 64'(dout),
                            64'(exp_out(din, rv[0], r, s[0], cap_of(r, s[0]))));
                        tick();
                    end
                end
            end
        end
        cfg_en = 1'b0;
        tick();
        #1;
        chk(dout == '0, "R12", "dout with lanes off", 64'(dout), 64'd0);

        // R7: reversal write ignored while enabled, captured when disabled and idle
        tick();
        cfg_role = 2'd1; cfg_split = 1'b0; cfg_rev = 1'b0; cfg_lanes = 2'd3;
        repeat (3) tick();
        cfg_en = 1'b1;
        tick();
        cfg_rev = 1'b1;
        repeat (3) tick();
        din = pattern(9);
        #1;
        chk(dout == exp_out(din, 1'b0, 1, 1'b0, 4), "R7", "rev ignored while enabled",
            64'(dout), 64'(exp_out(din, 1'b0, 1, 1'b0, 4)));
        tick();
        cfg_en = 1'b0;
        repeat (3) tick();
        cfg_en = 1'b1;
        tick();
        #1;
        chk(dout == exp_out(din, 1'b1, 1, 1'b0, 4), "R7", "rev captured when idle",
            64'(dout), 64'(exp_out(din, 1'b1, 1, 1'b0, 4)));
        tick();

        // decode sweep: R1 R2 R3 R10
        do_reset();
        exp_err = 0;
        for (int r = 0; r < 3; r++) begin
            for (int s = 0; s < 2; s++) begin
                for (int f = 0; f < 4; f++) begin
                    int cap;
                    int w;
                    int n;
                    bit bad;
                    cfg_en = 1'b0; cfg_rev = 1'b0; cfg_role = 2'(r);
                    cfg_split = s[0]; cfg_lanes = 2'(f); cfg_dly = '0;
                    repeat (3) tick();
                    cap = cap_of(r, s[0]);
                    w = want_of(f);
                    bad = (w == 0 || w > cap);
                    n = bad ? cap : w;
                    cfg_en = 1'b1;
                    tick();
                    #1;
                    if (r == 1 && f != 2)
                        chk(lane_en == therm(n), "R1", "lane count", 64'(lane_en), 64'(therm(n)));
                    else
                        chk(lane_en == therm(n), "R2", "clamped count", 64'(lane_en), 64'(therm(n)));
                    chk(idle == 1'b0, "R10", "zero delay lanes on in one edge", 64'(idle), 64'd0);
                    if (bad) exp_err = 1;
                    chk(cfg_err == exp_err[0], "R3", "sticky error", 64'(cfg_err), 64'(exp_err));
                    tick();
                    cfg_en = 1'b0;
                    tick();
                    #1;
                    chk(lane_en == '0, "R10", "zero delay lanes off in one edge", 64'(lane_en), 64'd0);
                end
            end
        end
        do_reset();
        #1;
        chk(cfg_err == 1'b0, "R3", "error cleared by reset", 64'(cfg_err), 64'd0);

        // stagger sweep: R8 R9 R11
        for (int d = 1; d <= 3; d++) begin
            tick();
            cfg_en = 1'b0; cfg_role = 2'd1; cfg_split = 1'b0;
            cfg_lanes = 2'd3; cfg_dly = DW'(d);
            repeat (4 * d + 3) tick();
            cfg_en = 1'b1;
            for (int c = 0; c <= 4 * d + 1; c++) begin
                int n;
                tick();
                #1;
                n = (c / d + 1 > 4) ? 4 : c / d + 1;
                chk(lane_en == therm(n), "R8", "ascending stagger", 64'(lane_en), 64'(therm(n)));
                chk(idle == 1'b0, "R11", "idle during power-up", 64'(idle), 64'd0);
            end
            tick();
            cfg_en = 1'b0;
            for (int c = 0; c <= 4 * d + 1; c++) begin
                int n;
                tick();
                #1;
                n = (c / d + 1 >= 4) ? 0 : 3 - c / d;
                chk(lane_en == therm(n), "R9", "descending stagger", 64'(lane_en), 64'(therm(n)));
                chk(idle == (n == 0), "R11", "idle after last lane off", 64'(idle), 64'(n == 0));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule